// File: doc/BRIEF.md
# Pixel Clock Generation Unit

This block produces the horizontal timebase and the outgoing pixel clock of a video output port. All waveforms are built as registered data in one core clock domain, `clk_i`, which runs at twice the master clock rate. One core tick is therefore half a master clock period. The horizontal clock is either the master clock itself or the master clock divided by a slower ratio (2 by default). A one-tick strobe marks every rising horizontal edge, and downstream exposure counters advance on that strobe.

The pixel clock follows the horizontal clock. It can be free-running. It can also be gated so that it pulses only during horizontal periods that carry a valid pixel, and it can be inverted. The divider choice, the gating mode and the polarity are taken up only at the boundary between horizontal periods, which is the last low tick of a period. A setting change can therefore never cut a pulse short. In gated mode, the data-valid strobe is sampled at that same boundary and decides the whole next period.

Top module: `pixclk_gen`

## Requirements
- R1: While `rst_ni` is low, `hclk_o`, `hclk_tick_o` and `pclk_o` are all 0. The active settings are divide-by-one, free-running and normal polarity.
- R2: When `div_sel_i` is 0 (divide-by-one), `hclk_o` has a period of 2 ticks: 1 tick high, then 1 tick low.
- R3: When `div_sel_i` is 1 (slow divide, ratio 2), `hclk_o` has a period of 4 ticks: 2 ticks high, then 2 ticks low.
- R4: `hclk_tick_o` is 1 for exactly the first tick of each horizontal period, which is the tick where `hclk_o` goes from 0 to 1. It is 0 on every other tick.
- R5: `div_sel_i`, `drdy_mode_i` and `pol_inv_i` are sampled only on the clock edge that ends a period (the edge after the period's last low tick). A value present on any other edge has no effect on the outputs.
- R6: With `drdy_mode_i` = 0 sampled, `pclk_o` equals `hclk_o`, or its inverse when `pol_inv_i` = 1 was sampled.
- R7: With `drdy_mode_i` = 1 sampled, the value of `pix_valid_i` at the same period-ending edge decides the next period. If it is 1, `pclk_o` follows `hclk_o` for that period. If it is 0, `pclk_o` stays at its rest level for the whole period.
- R8: Inversion is applied after gating. The rest level in gated mode is 0 for normal polarity and 1 for inverted polarity (`pol_inv_i` = 1).
- R9: After reset is released, the first clock edge starts a period. `hclk_o` and `hclk_tick_o` are 1 in the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the master clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | 1 | 0: divide-by-one, 1: slow divide |
| drdy_mode_i | input | 1 | 1: pixel clock pulses only for valid pixels |
| pol_inv_i | input | 1 | 1: invert the pixel clock |
| pix_valid_i | input | 1 | A valid pixel occupies the next period |
| hclk_o | output | 1 | Horizontal clock waveform |
| hclk_tick_o | output | 1 | One-tick strobe at each horizontal rising edge |
| pclk_o | output | 1 | Pixel clock waveform |

## Verification
A phase counter that is off by one shows up within one horizontal period. It appears as a wrong high/low split on `hclk_o` or as a misplaced `hclk_tick_o`. A setting register that loads off the boundary shows up at the ports in the tick after the stray input: the duty cycle changes or the pixel clock flips in the middle of a period. A gate that samples the valid strobe at the wrong time produces a pulse in an idle period, or drops one in a valid period, within the next period.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

  typedef enum logic {
    DIV_BY_ONE  = 1'b0,
    DIV_BY_SLOW = 1'b1
  } div_sel_e;

  // ticks of the core clock in one horizontal period for a given divide ratio
  function automatic int period_ticks(input int ratio);
    return 2 * ratio;
  endfunction

  // ticks spent high at the start of a period
  function automatic int high_ticks(input int ratio);
    return ratio;
  endfunction

endpackage

// File: rtl/pixclk_timebase.sv
module pixclk_timebase
  import pixclk_pkg::*;
#(
  parameter int DIV_SLOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_sel_i,
  output logic hclk_o,
  output logic hclk_tick_o,
  output logic bound_o
);

  localparam int PH_W = $clog2(period_ticks(DIV_SLOW));
  localparam logic [PH_W-1:0] LAST_FAST = PH_W'(period_ticks(1) - 1);
  localparam logic [PH_W-1:0] LAST_SLOW = PH_W'(period_ticks(DIV_SLOW) - 1);
  localparam logic [PH_W-1:0] HIGH_FAST = PH_W'(high_ticks(1));
  localparam logic [PH_W-1:0] HIGH_SLOW = PH_W'(high_ticks(DIV_SLOW));

  logic [PH_W-1:0] ph_q;
  div_sel_e        div_q;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] high_len;

  assign last_ph     = (div_q == DIV_BY_SLOW) ? LAST_SLOW : LAST_FAST;
  assign high_len    = (div_q == DIV_BY_SLOW) ? HIGH_SLOW : HIGH_FAST;
  assign bound_o     = (ph_q == last_ph);
  assign hclk_o      = (ph_q < high_len);
  assign hclk_tick_o = (ph_q == '0);

  // reset parks the counter in the last low tick so the first edge opens a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= LAST_FAST;
      div_q <= DIV_BY_ONE;
    end else if (bound_o) begin
      ph_q  <= '0;
      div_q <= div_sel_e'(div_sel_i);
    end else begin
      ph_q  <= ph_q + PH_W'(1);
    end
  end

  p_fast_duty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == DIV_BY_ONE && hclk_o) |=> !hclk_o);

  p_slow_duty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == DIV_BY_SLOW && hclk_tick_o) |=> hclk_o);

  p_tick_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_tick_o |-> (hclk_o && !$past(hclk_o)));

  p_div_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_o |=> $stable(div_q));

endmodule

// File: rtl/pixclk_shaper.sv
module pixclk_shaper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bound_i,
  input  logic hclk_i,
  input  logic drdy_mode_i,
  input  logic pol_inv_i,
  input  logic pix_valid_i,
  output logic pclk_o
);

  logic drdy_q;
  logic pol_q;
  logic gate_q;
  logic pass_en;

  // settings and the valid decision are frozen for a whole period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drdy_q <= 1'b0;
      pol_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (bound_i) begin
      drdy_q <= drdy_mode_i;
      pol_q  <= pol_inv_i;
      gate_q <= pix_valid_i;
    end
  end

  assign pass_en = !drdy_q || gate_q;
  assign pclk_o  = (hclk_i && pass_en) ^ pol_q;

  p_free_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && !drdy_mode_i) |=> (pclk_o == (hclk_i ^ $past(pol_inv_i))));

  p_idle_rest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && drdy_mode_i && !pix_valid_i) |=> (pclk_o == $past(pol_inv_i)));

  p_pol_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_i |=> $stable(pol_q));

endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen #(
  parameter int DIV_SLOW = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_sel_i,
  input  logic drdy_mode_i,
  input  logic pol_inv_i,
  input  logic pix_valid_i,
  output logic hclk_o,
  output logic hclk_tick_o,
  output logic pclk_o
);

  logic hclk_w;
  logic period_end_w;

  pixclk_timebase #(.DIV_SLOW(DIV_SLOW)) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_sel_i  (div_sel_i),
    .hclk_o     (hclk_w),
    .hclk_tick_o(hclk_tick_o),
    .bound_o    (period_end_w)
  );

  pixclk_shaper u_shaper (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bound_i    (period_end_w),
    .hclk_i     (hclk_w),
    .drdy_mode_i(drdy_mode_i),
    .pol_inv_i  (pol_inv_i),
    .pix_valid_i(pix_valid_i),
    .pclk_o     (pclk_o)
  );

  assign hclk_o = hclk_w;

  // a tick strobe may only appear while the horizontal clock is high
  p_strobe_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hclk_tick_o |-> hclk_o);

endmodule

// File: tb/pixclk_gen_tb_top.sv
module pixclk_gen_tb_top;

  localparam int SLOW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_sel = 1'b0, drdy = 1'b0, pol = 1'b0, valid = 1'b0;
  logic hclk, tick, pclk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [2:0] q_exp[$];
  string      q_tag[$];

  // reference state: ticks left in the current period, latched settings
  int m_left = 1;
  bit m_div = 0, m_dr = 0, m_pol = 0, m_gate = 0;

  always #4 clk = ~clk;

  pixclk_gen #(.DIV_SLOW(SLOW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_sel_i  (div_sel),
    .drdy_mode_i(drdy),
    .pol_inv_i  (pol),
    .pix_valid_i(valid),
    .hclk_o     (hclk),
    .hclk_tick_o(tick),
    .pclk_o     (pclk)
  );

  // driver: set inputs at a falling edge, predict the state after the next rising edge
  task automatic apply(input bit d, input bit dr, input bit pl, input bit v, input string tag);
    int per, el;
    bit h, t, p;
    div_sel = d; drdy = dr; pol = pl; valid = v;
    if (m_left == 1) begin
      m_div = d; m_dr = dr; m_pol = pl; m_gate = v;
      m_left = m_div ? 2 * SLOW : 2;
    end else begin
      m_left = m_left - 1;
    end
    per = m_div ? 2 * SLOW : 2;
    el  = per - m_left;
    h   = (el * 2 < per);
    t   = (el == 0);
    p   = (h && (!m_dr || m_gate)) ^ m_pol;
    q_exp.push_back({h, t, p});
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (q_exp.size() > 0) begin
        logic [2:0] e;
        string tg;
        e  = q_exp.pop_front();
        tg = q_tag.pop_front();
        n_vec++;
        if ({hclk, tick, pclk} !== e) begin
          n_bad++;
          $display("FAIL %s: {hclk,tick,pclk} got %b expected %b at %0t", tg, {hclk, tick, pclk}, e, $time);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset levels
    n_vec++;
    if ({hclk, tick, pclk} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: {hclk,tick,pclk} got %b expected 000", {hclk, tick, pclk});
    end
    rst_n = 1'b1;
    apply(0, 0, 0, 0, "R9 R4");
    for (int i = 0; i < 5; i++) apply(0, 0, 0, 0, "R2 R6");
    for (int i = 0; i < 9; i++) apply(1, 0, 0, 0, "R3 R4");
    // R5: settings held outside the boundary tick
    for (int i = 0; i < 6; i++) apply(0, 0, 0, 0, "R5 R2");
    for (int i = 0; i < 3; i++) apply(1, 0, 0, 0, "R5 R3");
    for (int i = 0; i < 12; i++) apply(1, (i % 4) == 1, (i % 4) == 2, 0, "R5");
    for (int i = 0; i < 24; i++) apply(1, 1, 0, (i % 3) == 0, "R7");
    for (int i = 0; i < 16; i++) apply(1, 1, 1, (i % 8) < 4, "R8 R7");
    for (int i = 0; i < 8; i++) apply(1, 0, 1, 0, "R8 R6");
    for (int i = 0; i < 12; i++) apply(0, 1, 0, (i % 3) == 1, "R7 R2");
    for (int i = 0; i < 8; i++) apply(0, 1, 1, 0, "R8");
    for (int i = 0; i < 6; i++) apply(0, 0, 0, 0, "R6");
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule